// File: doc/BRIEF.md
# Sensor Byte Queue with Dual Drain Paths

This block collects bytes from a sensor-side stream into a small first-in first-out queue. Each queued byte carries a loss marker. When the queue is full, a new arrival displaces the oldest byte, and the byte that becomes the new oldest is marked so the reader learns that data went missing ahead of it.

The host empties the queue over one of two paths. A selection input chooses the path. With the input low, the host uses a parallel register bus: one address returns a status byte for the oldest entry, and another returns its data byte and removes it. With the input high, the host uses a read-only SPI slave (clock idles low, data changes on the rising edge, the master samples on the falling edge). Each slave-select assertion removes one entry and shifts out a 16-bit word: the status byte first, then the data byte, each most significant bit first.

The status byte is laid out as follows:
- bit 0: the entry is valid.
- bit 1: the entry carries the loss marker.
- bits 3:2: always zero.
- bits 7:4: how many entries were queued when the byte was produced.

The SPI pins are brought into the system clock domain with two-stage synchronisers. The system clock must therefore run at least 8 times faster than the SPI clock.

Top module: `pipe_drain_port`

## Requirements
- R1: After reset the queue is empty, `reg_rdata` reads 0x00 and `spi_miso` is low.
- R2: Up to 8 bytes are held and are returned in arrival order.
- R3: A byte that arrives while 8 are held, with no removal in the same cycle, discards the oldest byte. The entry that becomes oldest then reports the loss marker (status bit 1), and the queue still holds 8 entries.
- R4: The status byte is {fill[3:0], 2'b00, lost, valid}: bit 0 is valid, bit 1 is lost, and bits 7:4 hold the entry count at the time the byte is produced. With the queue empty the status byte is 0x00.
- R5: With `use_spi` low, a read strobe at address 0x2D returns the status of the oldest entry on `reg_rdata` one cycle later and removes nothing.
- R6: With `use_spi` low, a read strobe at address 0x2E returns the oldest data byte one cycle later and removes that entry. On an empty queue it returns 0x00 and changes nothing.
- R7: A read at any other address returns 0x00. The write strobe has no effect on the queue at any address.
- R8: Removals through the path that is not selected are ignored. Register reads while `use_spi` is high return 0x00. SPI transactions while `use_spi` is low shift out 16 zero bits.
- R9: With `use_spi` high, each falling edge of `spi_ssn` removes one entry. The block then shifts {status, data} MSB first, updating MISO after each rising SCK edge so the value is stable at the following falling edge.
- R10: An SPI transaction on an empty queue shifts out 0x0000 and removes nothing.
- R11: `spi_miso` is low whenever `spi_ssn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A new sensor byte is present this cycle |
| in_byte | input | 8 | Sensor byte to queue |
| use_spi | input | 1 | Path select: 1 = SPI drain, 0 = register drain |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Register write data (no writable targets) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Registered read data |
| spi_ssn | input | 1 | SPI slave select, active low |
| spi_sck | input | 1 | SPI clock from master |
| spi_miso | output | 1 | SPI serial data to master |

## Verification
A table of bursts of different lengths (1, 3, 5 and 8 bytes, with distinct base values) is drained alternately through registers and SPI. These bursts tell apart ordering faults, fill-count faults and bit-order faults on the serial path. An overfill of ten bytes shows whether the right entries are discarded and whether the loss marker lands on the new oldest entry rather than elsewhere. Cross-path patterns show whether the unselected path disturbs the queue: an SPI frame in register mode and a register read in SPI mode, each followed by a drain through the selected path. Empty-queue reads on both paths, writes, and an unmapped address cover the cases with no effect.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 7;
  localparam logic [6:0]  ADDR_STAT = 7'h2D;
  localparam logic [6:0]  ADDR_DATA = 7'h2E;

  // status layout: fill count high nibble, loss marker bit 1, valid bit 0
  function automatic logic [7:0] status_byte(input logic valid, input logic lost,
                                             input logic [3:0] fill);
    return {fill, 2'b00, lost, valid};
  endfunction
endpackage

// File: rtl/pdp_fifo.sv
module pdp_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_data_o,
  output logic          head_lost_o,
  output logic [CW-1:0] level_o,
  output logic          empty_o,
  output logic          overwrite_o
);
  logic [W-1:0]     data_q [DEPTH];
  logic [DEPTH-1:0] lost_q;
  logic [PW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    level_q;
  logic             full, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full        = (level_q == CW'(DEPTH));
  assign empty_o     = (level_q == '0);
  assign do_pop      = pop_i & ~empty_o;
  assign overwrite_o = push_i & full & ~do_pop;
  assign head_data_o = data_q[rd_q];
  assign head_lost_o = lost_q[rd_q];
  assign level_o     = level_q;

  always_ff @(posedge clk) begin
    if (push_i) data_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q  <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      level_q <= '0;
    end else begin
      if (push_i) begin
        lost_q[wr_q] <= 1'b0;
        wr_q         <= bump(wr_q);
      end
      if (overwrite_o) lost_q[bump(rd_q)] <= 1'b1;
      if (do_pop || overwrite_o) rd_q <= bump(rd_q);
      if (push_i && !do_pop && !full) level_q <= level_q + CW'(1);
      else if (do_pop && !push_i)     level_q <= level_q - CW'(1);
    end
  end

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CW'(DEPTH));
  p_overwrite_stays_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overwrite_o |=> (level_q == CW'(DEPTH)));
  p_overwrite_marks_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overwrite_o |=> head_lost_o);
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/pdp_spi_tx.sv
module pdp_spi_tx #(
  parameter int unsigned FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          ssn_i,
  input  logic [FW-1:0] frame_i,
  output logic          start_o,
  output logic          miso_o
);
  // [0],[1] synchroniser stages, [2] previous value for edge detection
  logic [2:0]    sck_q, ssn_q;
  logic [FW-1:0] shreg_q;
  logic          tx_q, sck_rise, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      ssn_q <= '1;
    end else begin
      sck_q <= {sck_q[1:0], sck_i};
      ssn_q <= {ssn_q[1:0], ssn_i};
    end
  end

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign start_o  = ~ssn_q[1] & ssn_q[2];
  assign active   = ~ssn_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      tx_q    <= 1'b0;
    end else if (start_o) begin
      shreg_q <= frame_i;
      tx_q    <= 1'b0;
    end else if (active && sck_rise) begin
      tx_q    <= shreg_q[FW-1];
      shreg_q <= {shreg_q[FW-2:0], 1'b0};
    end
  end

  assign miso_o = ~ssn_i & tx_q;
endmodule

// File: rtl/pipe_drain_port.sv
module pipe_drain_port #(
  parameter int unsigned DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       use_spi,
  input  logic [6:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  input  logic       reg_wr,
  output logic [7:0] reg_rdata,
  input  logic       spi_ssn,
  input  logic       spi_sck,
  output logic       spi_miso
);
  import pdp_pkg::*;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned FW = 2 * BYTE_W;

  logic [7:0]    head_data, head_status, head_data_vis;
  logic          head_lost, empty, overwrite;
  logic [CW-1:0] level;
  logic          spi_start, reg_pop, spi_pop, fifo_pop;
  logic [FW-1:0] frame;
  logic [7:0]    rdata_q;
  logic          unused_wr;

  assign unused_wr = ^{reg_wdata, reg_wr};

  pdp_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(in_valid), .data_i(in_byte),
    .pop_i(fifo_pop), .head_data_o(head_data), .head_lost_o(head_lost),
    .level_o(level), .empty_o(empty), .overwrite_o(overwrite)
  );

  assign head_status   = status_byte(~empty, head_lost & ~empty, 4'(level));
  assign head_data_vis = empty ? 8'h00 : head_data;
  assign frame         = use_spi ? {head_status, head_data_vis} : '0;

  pdp_spi_tx #(.FW(FW)) u_spi (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .ssn_i(spi_ssn),
    .frame_i(frame), .start_o(spi_start), .miso_o(spi_miso)
  );

  assign spi_pop  = spi_start & use_spi;
  assign reg_pop  = reg_rd & ~use_spi & (reg_addr == ADDR_DATA);
  assign fifo_pop = spi_pop | reg_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_rd) begin
      if (use_spi)                    rdata_q <= 8'h00;
      else if (reg_addr == ADDR_STAT) rdata_q <= head_status;
      else if (reg_addr == ADDR_DATA) rdata_q <= head_data_vis;
      else                            rdata_q <= 8'h00;
    end
  end
  assign reg_rdata = rdata_q;

  p_spi_off_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && !use_spi && !in_valid) |=> $stable(level));
  p_reg_off_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && use_spi) |=> (reg_rdata == 8'h00));
  p_stat_no_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !use_spi && reg_addr == ADDR_STAT && !in_valid) |=> $stable(level));
endmodule

// File: tb/pipe_drain_port_bench.sv
module pipe_drain_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, use_spi = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic spi_ssn = 1'b1, spi_sck = 1'b0;
  logic [7:0] in_byte = '0, reg_wdata = '0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_rdata;
  logic spi_miso;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // {mode(1=SPI), count[3:0], base[7:0]}
  localparam logic [12:0] VEC [4] = '{
    {1'b0, 4'd3, 8'h10}, {1'b1, 4'd5, 8'hA5},
    {1'b0, 4'd8, 8'h00}, {1'b1, 4'd1, 8'hFF}};

  pipe_drain_port u_pipe_drain_port (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .use_spi(use_spi), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
    .spi_ssn(spi_ssn), .spi_sck(spi_sck), .spi_miso(spi_miso));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] exp_stat(input int fill, input int lost, input int valid);
    return 8'(fill * 16 + lost * 2 + valid);
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk) in_valid = 1'b1; in_byte = b;
    @(negedge clk) in_valid = 1'b0;
  endtask

  task automatic reg_read(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk) reg_addr = a; reg_rd = 1'b1;
    @(negedge clk) reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] v);
    @(negedge clk) reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic spi_xfer(output logic [15:0] got);
    got = '0;
    @(negedge clk) spi_ssn = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < 16; b++) begin
      spi_sck = 1'b1;
      repeat (6) @(negedge clk);
      got = {got[14:0], spi_miso};
      spi_sck = 1'b0;
      repeat (6) @(negedge clk);
    end
    spi_ssn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] fr;
    repeat (4) @(negedge clk);
    chk("R1 rdata after reset", 16'(reg_rdata), 16'h00);
    chk("R11 miso in reset", 16'(spi_miso), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 miso idle", 16'(spi_miso), 16'h0);
    reg_read(7'h2D, d);
    chk("R1 R4 empty status", 16'(d), 16'h00);

    // table walk: bursts drained through either path (R2 R4 R5 R6 R9)
    for (int v = 0; v < 4; v++) begin
      int n;
      logic [7:0] base;
      use_spi = VEC[v][12];
      n = int'(VEC[v][11:8]);
      base = VEC[v][7:0];
      for (int i = 0; i < n; i++) push(8'(base + 8'(i)));
      for (int i = 0; i < n; i++) begin
        if (use_spi) begin
          spi_xfer(fr);
          chk("R9 R2 spi frame", fr, {exp_stat(n - i, 0, 1), 8'(base + 8'(i))});
          chk("R11 miso after frame", 16'(spi_miso), 16'h0);
        end else begin
          reg_read(7'h2D, d);
          chk("R5 R4 status", 16'(d), 16'(exp_stat(n - i, 0, 1)));
          reg_read(7'h2E, d);
          chk("R6 R2 data", 16'(d), 16'(8'(base + 8'(i))));
        end
      end
      use_spi = 1'b0;
      reg_read(7'h2D, d);
      chk("R4 drained", 16'(d), 16'h00);
    end

    // overfill: 10 bytes, oldest two discarded
    use_spi = 1'b1;
    for (int i = 0; i < 10; i++) push(8'(8'h30 + 8'(i)));
    spi_xfer(fr);
    chk("R3 lost marker on new head", fr, 16'h8332);
    spi_xfer(fr);
    chk("R3 marker only once", fr, 16'h7133);
    use_spi = 1'b0;
    for (int i = 0; i < 6; i++) begin
      reg_read(7'h2D, d);
      chk("R3 R4 rest status", 16'(d), 16'(exp_stat(6 - i, 0, 1)));
      reg_read(7'h2E, d);
      chk("R3 rest data", 16'(d), 16'(8'(8'h34 + 8'(i))));
    end

    // empty reads on both paths
    reg_read(7'h2E, d);
    chk("R6 empty data read", 16'(d), 16'h00);
    use_spi = 1'b1;
    spi_xfer(fr);
    chk("R10 empty frame", fr, 16'h0000);

    // cross-path removal ignored
    use_spi = 1'b0;
    push(8'h5A);
    spi_xfer(fr);
    chk("R8 spi in register mode", fr, 16'h0000);
    reg_read(7'h2D, d);
    chk("R8 entry kept after spi", 16'(d), 16'h11);
    use_spi = 1'b1;
    reg_read(7'h2E, d);
    chk("R8 register read in spi mode", 16'(d), 16'h00);
    spi_xfer(fr);
    chk("R8 entry kept after reg read", fr, 16'h115A);

    // writes and unmapped address
    use_spi = 1'b0;
    push(8'h77);
    reg_write(7'h2E, 8'hFF);
    reg_write(7'h2D, 8'hFF);
    reg_read(7'h00, d);
    chk("R7 unmapped read", 16'(d), 16'h00);
    reg_read(7'h2D, d);
    chk("R7 write no effect status", 16'(d), 16'h11);
    reg_read(7'h2E, d);
    chk("R7 write no effect data", 16'(d), 16'h77);
    chk("R11 miso idle at end", 16'(spi_miso), 16'h0);

    done = 1'b1;
    finish_run();
  end
endmodule